// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block sits at the instruction boundary of a small 16-bit real-mode core and carries out interrupt entry. A raise request latches an 8-bit vector number and marks it pending. At each boundary strobe the core presents its live FLAGS, CS, IP, SS and SP. The sequencer then either stops the core (halt), runs the entry sequence on a word-wide memory port, or hands the core's state straight back so fetching can continue.

The entry sequence always has the same five memory accesses. It saves the old FLAGS, then the old CS. It reads the new CS from the vector table. It saves the old IP and finally reads the new IP. The table entry for vector n sits at physical address 4n, with the IP word at 4n and the CS word at 4n+2. When the sequence ends, one resume pulse returns the new CS, IP, SP and FLAGS together with the physical fetch address. The core does the opcode fetches at that address and steps IP by one for each fetched byte.

Top module: `rmi_entry_seq`

## Requirements
- R1: After synchronous reset, busy, halted, resume_valid and mem_valid are low and no request is pending.
- R2: A boundary with nothing serviceable pending gives, on the next cycle, a one-cycle resume_valid that returns the input CS, IP, SP and FLAGS unchanged. resume_fetch_addr equals ((CS << 4) + IP) modulo 2^20.
- R3: A raise_valid pulse latches raise_vec and marks it pending. No memory access happens until the next boundary.
- R4: Vectors 0 and 2 are serviced whatever the value of FLAGS bit 9 (interrupt enable). Any other vector is serviced only when FLAGS bit 9 is 1. A vector that is masked gets a plain resume and stays pending.
- R5: An entry performs exactly five accesses, in this order: write FLAGS at stack(SP-2), write CS at stack(SP-4), read 4v+2, write IP at stack(SP-6), read 4v. Here stack(x) = ((SS << 4) + x) modulo 2^20, and x is a 16-bit wrapping offset.
- R6: When an entry ends, resume_valid returns CS = the word read from 4v+2 and IP = the word read from 4v. SP = SP-6 (16-bit wrap). FLAGS equals the input value with bits 9 and 8 cleared. The fetch address follows from the new CS and IP as in R2.
- R7: Each access holds mem_write, mem_addr and mem_wdata stable while mem_ready is low. busy is high from the cycle after the boundary until the final access is accepted, and it falls in the cycle where resume_valid rises.
- R8: An entry consumes its request: the next boundary gives a plain resume unless a new raise has arrived.
- R9: A raise that arrives while an entry is running is kept pending and is serviced at the following boundary.
- R10: A halt request is sticky until reset and is checked before any interrupt. At a boundary it raises halted, with no resume and no memory access. Later boundaries are ignored.
- R11: Only one request is held. A second raise before service replaces the pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_valid | input | 1 | Interrupt raise strobe |
| raise_vec | input | 8 | Vector number of the raise |
| halt_req | input | 1 | Halt request strobe, latched |
| boundary | input | 1 | Core reached an instruction boundary (only while not busy) |
| flags_in | input | 16 | Current FLAGS |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ready on a read |
| busy | output | 1 | Entry sequence in progress |
| halted | output | 1 | Core is stopped |
| resume_valid | output | 1 | One-cycle pulse: continue fetching with the values below |
| resume_cs | output | 16 | CS to fetch with |
| resume_ip | output | 16 | IP to fetch with |
| resume_sp | output | 16 | SP after the boundary |
| resume_flags | output | 16 | FLAGS after the boundary |
| resume_fetch_addr | output | 20 | Physical opcode fetch address |

## Verification
The block is driven with randomly chosen segment, offset, stack and flag words, with and without a prior raise, and the vector is taken from 0, 2 or a random value. This separates the always-serviced vectors from the maskable ones under both settings of the interrupt-enable bit. Random memory stalls show whether each access is held steady and whether the order and stack offsets survive back-pressure. Directed cases cover the remaining corners. A masked request must stay pending. A second raise must replace the first. A raise during an entry must surface at the next boundary. A raise with no boundary must produce no memory access. A halt must override a pending interrupt.

// File: rtl/rmi_pkg.sv
package rmi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_HALT   = 2'd2
  } seq_state_t;

  localparam int STEP_W = 3;
  // Entry access order; the position of each step is behaviour.
  localparam logic [STEP_W-1:0] STEP_SAVE_FLAGS = 3'd0;
  localparam logic [STEP_W-1:0] STEP_SAVE_CS    = 3'd1;
  localparam logic [STEP_W-1:0] STEP_LOAD_CS    = 3'd2;
  localparam logic [STEP_W-1:0] STEP_SAVE_IP    = 3'd3;
  localparam logic [STEP_W-1:0] STEP_LOAD_IP    = 3'd4;
  localparam logic [STEP_W-1:0] STEP_LAST       = STEP_LOAD_IP;

  localparam int IE_BIT   = 9;
  localparam int TRAP_BIT = 8;
endpackage

// File: rtl/rmi_phys_addr.sv
module rmi_phys_addr #(
  parameter int WORD_W  = 16,
  parameter int PADDR_W = 20,
  parameter int SHIFT   = 4
) (
  input  logic [WORD_W-1:0]  seg,
  input  logic [WORD_W-1:0]  off,
  output logic [PADDR_W-1:0] phys
);
  logic [PADDR_W-1:0] seg_ext;
  logic [PADDR_W-1:0] off_ext;

  always_comb begin
    seg_ext = PADDR_W'(seg) << SHIFT;
    off_ext = PADDR_W'(off);
    phys    = seg_ext + off_ext;
  end
endmodule

// File: rtl/rmi_gate.sv
module rmi_gate #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] FORCE_VEC_A = 0,
  parameter logic [VEC_W-1:0] FORCE_VEC_B = 2
) (
  input  logic             pend,
  input  logic [VEC_W-1:0] vec,
  input  logic             ie,
  output logic             take
);
  logic forced;

  always_comb begin
    forced = (vec == FORCE_VEC_A) || (vec == FORCE_VEC_B);
    take   = pend && (forced || ie);
  end
endmodule

// File: rtl/rmi_step_gen.sv
module rmi_step_gen
  import rmi_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int VEC_W   = 8,
  parameter int PADDR_W = 20,
  parameter int SHIFT   = 4
) (
  input  logic [STEP_W-1:0]  step,
  input  logic [VEC_W-1:0]   vec,
  input  logic [WORD_W-1:0]  ss,
  input  logic [WORD_W-1:0]  sp,
  input  logic [WORD_W-1:0]  flags,
  input  logic [WORD_W-1:0]  cs,
  input  logic [WORD_W-1:0]  ip,
  output logic               op_write,
  output logic [PADDR_W-1:0] op_addr,
  output logic [WORD_W-1:0]  op_wdata
);
  localparam int ENTRY_BYTES = WORD_W / 8;
  localparam int TABLE_SHIFT = 2;

  logic [WORD_W-1:0]  push_off;
  logic [PADDR_W-1:0] stack_addr;
  logic [PADDR_W-1:0] table_addr;

  always_comb begin
    case (step)
      STEP_SAVE_FLAGS: push_off = sp - WORD_W'(1 * ENTRY_BYTES);
      STEP_SAVE_CS:    push_off = sp - WORD_W'(2 * ENTRY_BYTES);
      default:         push_off = sp - WORD_W'(3 * ENTRY_BYTES);
    endcase
  end

  rmi_phys_addr #(.WORD_W(WORD_W), .PADDR_W(PADDR_W), .SHIFT(SHIFT)) stack_i (
    .seg (ss),
    .off (push_off),
    .phys(stack_addr)
  );

  always_comb begin
    table_addr = PADDR_W'(vec) << TABLE_SHIFT;
    if (step == STEP_LOAD_CS) table_addr = table_addr + PADDR_W'(ENTRY_BYTES);
  end

  always_comb begin
    op_write = 1'b1;
    op_addr  = stack_addr;
    op_wdata = '0;
    case (step)
      STEP_SAVE_FLAGS: op_wdata = flags;
      STEP_SAVE_CS:    op_wdata = cs;
      STEP_SAVE_IP:    op_wdata = ip;
      default: begin
        op_write = 1'b0;
        op_addr  = table_addr;
      end
    endcase
  end
endmodule

// File: rtl/rmi_entry_seq.sv
module rmi_entry_seq
  import rmi_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int VEC_W   = 8,
  parameter int PADDR_W = 20,
  parameter int SHIFT   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raise_valid,
  input  logic [VEC_W-1:0]   raise_vec,
  input  logic               halt_req,
  input  logic               boundary,
  input  logic [WORD_W-1:0]  flags_in,
  input  logic [WORD_W-1:0]  cs_in,
  input  logic [WORD_W-1:0]  ip_in,
  input  logic [WORD_W-1:0]  ss_in,
  input  logic [WORD_W-1:0]  sp_in,
  output logic               mem_valid,
  output logic               mem_write,
  output logic [PADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               busy,
  output logic               halted,
  output logic               resume_valid,
  output logic [WORD_W-1:0]  resume_cs,
  output logic [WORD_W-1:0]  resume_ip,
  output logic [WORD_W-1:0]  resume_sp,
  output logic [WORD_W-1:0]  resume_flags,
  output logic [PADDR_W-1:0] resume_fetch_addr
);
  localparam int FRAME_BYTES = 3 * (WORD_W / 8);
  localparam logic [WORD_W-1:0] CLR_MASK =
    ~((WORD_W'(1) << IE_BIT) | (WORD_W'(1) << TRAP_BIT));

  seq_state_t         state;
  logic [STEP_W-1:0]  step;
  logic               pend;
  logic [VEC_W-1:0]   pend_vec;
  logic               halt_flag;
  logic               halt_now;
  logic               take;
  logic               start;

  logic [VEC_W-1:0]   snap_vec;
  logic [WORD_W-1:0]  snap_flags, snap_cs, snap_ip, snap_ss, snap_sp;
  logic [WORD_W-1:0]  new_cs;

  logic [STEP_W-1:0]  gen_step;
  logic [VEC_W-1:0]   gen_vec;
  logic [WORD_W-1:0]  gen_flags, gen_cs, gen_ip, gen_ss, gen_sp;
  logic               gen_write;
  logic [PADDR_W-1:0] gen_addr;
  logic [WORD_W-1:0]  gen_wdata;

  rmi_gate #(.VEC_W(VEC_W)) gate_i (
    .pend(pend),
    .vec (pend_vec),
    .ie  (flags_in[IE_BIT]),
    .take(take)
  );

  always_comb begin
    halt_now = halt_flag || halt_req;
    start    = (state == ST_IDLE) && boundary && !halt_now && take;
  end

  // While idle the generator sees the live state and prepares the first access;
  // during the sequence it sees the snapshot and prepares the next access.
  always_comb begin
    if (state == ST_IDLE) begin
      gen_step  = STEP_SAVE_FLAGS;
      gen_vec   = pend_vec;
      gen_flags = flags_in;
      gen_cs    = cs_in;
      gen_ip    = ip_in;
      gen_ss    = ss_in;
      gen_sp    = sp_in;
    end else begin
      gen_step  = step + STEP_W'(1);
      gen_vec   = snap_vec;
      gen_flags = snap_flags;
      gen_cs    = snap_cs;
      gen_ip    = snap_ip;
      gen_ss    = snap_ss;
      gen_sp    = snap_sp;
    end
  end

  rmi_step_gen #(.WORD_W(WORD_W), .VEC_W(VEC_W), .PADDR_W(PADDR_W), .SHIFT(SHIFT)) gen_i (
    .step    (gen_step),
    .vec     (gen_vec),
    .ss      (gen_ss),
    .sp      (gen_sp),
    .flags   (gen_flags),
    .cs      (gen_cs),
    .ip      (gen_ip),
    .op_write(gen_write),
    .op_addr (gen_addr),
    .op_wdata(gen_wdata)
  );

  rmi_phys_addr #(.WORD_W(WORD_W), .PADDR_W(PADDR_W), .SHIFT(SHIFT)) fetch_i (
    .seg (resume_cs),
    .off (resume_ip),
    .phys(resume_fetch_addr)
  );

  // Request latch: a raise in the same cycle as a start survives the start.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_vec  <= '0;
      halt_flag <= 1'b0;
    end else begin
      halt_flag <= halt_now;
      if (raise_valid) begin
        pend     <= 1'b1;
        pend_vec <= raise_vec;
      end else if (start) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      step         <= '0;
      busy         <= 1'b0;
      halted       <= 1'b0;
      mem_valid    <= 1'b0;
      mem_write    <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      resume_valid <= 1'b0;
      resume_cs    <= '0;
      resume_ip    <= '0;
      resume_sp    <= '0;
      resume_flags <= '0;
      snap_vec     <= '0;
      snap_flags   <= '0;
      snap_cs      <= '0;
      snap_ip      <= '0;
      snap_ss      <= '0;
      snap_sp      <= '0;
      new_cs       <= '0;
    end else begin
      resume_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (boundary) begin
            if (halt_now) begin
              state  <= ST_HALT;
              halted <= 1'b1;
            end else if (take) begin
              state      <= ST_ACCESS;
              step       <= STEP_SAVE_FLAGS;
              busy       <= 1'b1;
              mem_valid  <= 1'b1;
              mem_write  <= gen_write;
              mem_addr   <= gen_addr;
              mem_wdata  <= gen_wdata;
              snap_vec   <= pend_vec;
              snap_flags <= flags_in;
              snap_cs    <= cs_in;
              snap_ip    <= ip_in;
              snap_ss    <= ss_in;
              snap_sp    <= sp_in;
            end else begin
              resume_valid <= 1'b1;
              resume_cs    <= cs_in;
              resume_ip    <= ip_in;
              resume_sp    <= sp_in;
              resume_flags <= flags_in;
            end
          end
        end
        ST_ACCESS: begin
          if (mem_ready) begin
            if (step == STEP_LOAD_CS) new_cs <= mem_rdata;
            if (step == STEP_LAST) begin
              state        <= ST_IDLE;
              busy         <= 1'b0;
              mem_valid    <= 1'b0;
              resume_valid <= 1'b1;
              resume_cs    <= new_cs;
              resume_ip    <= mem_rdata;
              resume_sp    <= snap_sp - WORD_W'(FRAME_BYTES);
              resume_flags <= snap_flags & CLR_MASK;
            end else begin
              step      <= gen_step;
              mem_write <= gen_write;
              mem_addr  <= gen_addr;
              mem_wdata <= gen_wdata;
            end
          end
        end
        default: begin
          halted <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/rmi_entry_seq_chk.sv
module rmi_entry_seq_chk #(
  parameter int WORD_W  = 16,
  parameter int PADDR_W = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               mem_valid,
  input logic               mem_write,
  input logic [PADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0]  mem_wdata,
  input logic               mem_ready,
  input logic               busy,
  input logic               halted,
  input logic               resume_valid
);
  assert_hold_access_R7: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_wdata) && $stable(mem_write));

  assert_access_in_entry_R7: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy);

  assert_end_gives_resume_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> resume_valid);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> !resume_valid && !mem_valid && !busy);
endmodule

bind rmi_entry_seq rmi_entry_seq_chk #(.WORD_W(WORD_W), .PADDR_W(PADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .mem_valid   (mem_valid),
  .mem_write   (mem_write),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ready   (mem_ready),
  .busy        (busy),
  .halted      (halted),
  .resume_valid(resume_valid)
);

// File: tb/rmi_entry_seq_tb.sv
module rmi_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raise_valid = 1'b0;
  logic [7:0]  raise_vec = '0;
  logic        halt_req = 1'b0;
  logic        boundary = 1'b0;
  logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        busy, halted, resume_valid;
  logic [15:0] resume_cs, resume_ip, resume_sp, resume_flags;
  logic [19:0] resume_fetch_addr;

  int checks = 0, fails = 0, cycles = 0;
  bit m_pend = 0;
  logic [7:0] m_vec = '0;

  logic        lg_write [8];
  logic [19:0] lg_addr [8];
  logic [15:0] lg_wdata [8];
  int          lg_n = 0;
  bit          held = 0;
  logic        h_write;
  logic [19:0] h_addr;
  logic [15:0] h_wdata;

  always #4 clk = ~clk;

  rmi_entry_seq dut_i (
    .clk(clk), .rst(rst), .raise_valid(raise_valid), .raise_vec(raise_vec),
    .halt_req(halt_req), .boundary(boundary), .flags_in(flags_in), .cs_in(cs_in),
    .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .halted(halted),
    .resume_valid(resume_valid), .resume_cs(resume_cs), .resume_ip(resume_ip),
    .resume_sp(resume_sp), .resume_flags(resume_flags),
    .resume_fetch_addr(resume_fetch_addr)
  );

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h000} ^ 16'h5A3C;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    return (20'(seg) << 4) + 20'(off);
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  // Memory observer: records accepted accesses and checks holding under stall (R7)
  always @(posedge clk) begin
    if (!rst) begin
      if (held) begin
        chk(mem_valid && mem_addr == h_addr && mem_wdata == h_wdata && mem_write == h_write,
            "R7", "access held during stall", {12'h0, mem_addr}, {12'h0, h_addr});
      end
      if (mem_valid && mem_ready && lg_n < 8) begin
        lg_write[lg_n] = mem_write;
        lg_addr[lg_n]  = mem_addr;
        lg_wdata[lg_n] = mem_wdata;
        lg_n++;
      end
      held    = mem_valid && !mem_ready;
      h_addr  = mem_addr;
      h_wdata = mem_wdata;
      h_write = mem_write;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(0, "WDOG", "watchdog expired", cycles, 150000);
        summary();
      end
    end
  end

  task automatic do_raise(input logic [7:0] v);
    @(negedge clk);
    raise_valid = 1'b1;
    raise_vec   = v;
    @(negedge clk);
    raise_valid = 1'b0;
    m_pend = 1;
    m_vec  = v;
  endtask

  task automatic run_boundary(input logic [15:0] cs, ip, sp, ss, fl,
                              input bit mid, input logic [7:0] mvec);
    bit exp_entry, got, busy_ok;
    logic [7:0] v;
    logic [19:0] ea [5];
    logic        ew [5];
    logic [15:0] ed [5];
    logic [15:0] ecs, eip, esp, efl;
    exp_entry = m_pend && (m_vec == 8'd0 || m_vec == 8'd2 || fl[9]);
    v = m_vec;
    @(negedge clk);
    cs_in = cs; ip_in = ip; sp_in = sp; ss_in = ss; flags_in = fl;
    lg_n = 0;
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    got = 0;
    busy_ok = 1;
    for (int n = 0; n < 300 && !got; n++) begin
      if (resume_valid) got = 1;
      else begin
        if (!busy && exp_entry) busy_ok = 0;
        if (mid && exp_entry && n == 1) begin
          raise_valid = 1'b1;
          raise_vec   = mvec;
        end else raise_valid = 1'b0;
        @(negedge clk);
      end
    end
    raise_valid = 1'b0;
    if (exp_entry) m_pend = 0;
    if (mid && exp_entry) begin
      m_pend = 1;
      m_vec  = mvec;
    end
    chk(got, "R2/R6", "resume pulse seen", 32'(got), 1);
    chk(busy_ok && !busy, "R7", "busy through entry, low at resume", 32'(busy), 0);
    if (exp_entry) begin
      ea[0] = phys(ss, sp - 16'd2); ew[0] = 1; ed[0] = fl;
      ea[1] = phys(ss, sp - 16'd4); ew[1] = 1; ed[1] = cs;
      ea[2] = (20'(v) << 2) + 20'd2; ew[2] = 0; ed[2] = '0;
      ea[3] = phys(ss, sp - 16'd6); ew[3] = 1; ed[3] = ip;
      ea[4] = 20'(v) << 2;           ew[4] = 0; ed[4] = '0;
      ecs = mem_word(ea[2]); eip = mem_word(ea[4]);
      esp = sp - 16'd6;      efl = fl & 16'hFCFF;
      chk(lg_n == 5, "R5", "entry access count", lg_n, 5);
      for (int k = 0; k < 5 && k < lg_n; k++) begin
        chk(lg_addr[k] == ea[k] && lg_write[k] == ew[k], "R5", "access address/kind",
            {11'h0, lg_write[k], lg_addr[k]}, {11'h0, ew[k], ea[k]});
        if (ew[k]) chk(lg_wdata[k] == ed[k], "R5", "pushed word", lg_wdata[k], ed[k]);
      end
    end else begin
      ecs = cs; eip = ip; esp = sp; efl = fl;
      chk(lg_n == 0, "R2/R4/R8", "no memory access without entry", lg_n, 0);
    end
    chk(resume_cs == ecs, exp_entry ? "R6" : "R2", "resume CS", resume_cs, ecs);
    chk(resume_ip == eip, exp_entry ? "R6" : "R2", "resume IP", resume_ip, eip);
    chk(resume_sp == esp, exp_entry ? "R6" : "R2", "resume SP", resume_sp, esp);
    chk(resume_flags == efl, exp_entry ? "R6" : "R2", "resume FLAGS", resume_flags, efl);
    chk(resume_fetch_addr == phys(ecs, eip), "R2", "fetch address",
        resume_fetch_addr, phys(ecs, eip));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !halted && !resume_valid && !mem_valid, "R1", "reset outputs",
        {busy, halted, resume_valid, mem_valid}, 0);
    run_boundary(16'h1234, 16'h0010, 16'h0100, 16'h2000, 16'h0202, 0, 0); // R1 nothing pending

    // R3: raise alone causes no memory activity
    do_raise(8'h21);
    lg_n = 0;
    repeat (10) @(negedge clk);
    chk(lg_n == 0 && !busy, "R3", "no access before boundary", lg_n, 0);
    // R4: masked vector stays pending, then served with IE set
    run_boundary(16'hF000, 16'hFFF0, 16'h0004, 16'hFFFF, 16'h0100, 0, 0);
    chk(m_pend == 1, "R4", "masked vector still pending (model)", 32'(m_pend), 1);
    run_boundary(16'hF000, 16'hFFF0, 16'h0004, 16'hFFFF, 16'h0300, 0, 0);
    // R8: consumed
    run_boundary(16'h0040, 16'h0000, 16'h8000, 16'h0000, 16'h0200, 0, 0);
    // R4: vectors 0 and 2 ignore IE; vector 1 does not
    do_raise(8'h00);
    run_boundary(16'h0700, 16'h0123, 16'h0000, 16'h0030, 16'h0000, 0, 0);
    do_raise(8'h02);
    run_boundary(16'h0701, 16'h0124, 16'h0002, 16'h0031, 16'h0100, 0, 0);
    do_raise(8'h01);
    run_boundary(16'h0702, 16'h0125, 16'h1000, 16'h0032, 16'h0000, 0, 0);
    run_boundary(16'h0702, 16'h0125, 16'h1000, 16'h0032, 16'h0200, 0, 0);
    // R11: second raise replaces the first
    do_raise(8'h05);
    do_raise(8'h09);
    run_boundary(16'h3333, 16'h4444, 16'h0F00, 16'h5555, 16'h0246, 0, 0);
    // R9: raise during an entry is served at the next boundary
    do_raise(8'h10);
    run_boundary(16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h0200, 1, 8'h40);
    chk(m_pend == 1, "R9", "mid-entry raise kept (model)", 32'(m_pend), 1);
    run_boundary(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0200, 0, 0);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] rv;
      case ($urandom % 4)
        0: rv = 8'h00;
        1: rv = 8'h02;
        default: rv = 8'($urandom);
      endcase
      if ($urandom % 2) do_raise(rv);
      run_boundary(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                   16'($urandom), ($urandom % 5) == 0, 8'($urandom));
    end

    // R10: halt overrides a pending interrupt and is sticky
    do_raise(8'h00);
    @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    lg_n = 0;
    repeat (3) @(negedge clk);
    chk(!halted, "R10", "halt waits for boundary", 32'(halted), 0);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk(halted && !resume_valid, "R10", "halted at boundary, no resume",
        {halted, resume_valid}, 2'b10);
    repeat (10) @(negedge clk);
    chk(lg_n == 0 && !busy, "R10", "no entry after halt", lg_n, 0);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk(halted && !resume_valid, "R10", "later boundary ignored",
        {halted, resume_valid}, 2'b10);
    repeat (4) @(negedge clk);
    chk(halted, "R10", "halt sticky", 32'(halted), 1);
    summary();
  end
endmodule